// File: doc/BRIEF.md
# Line-Crossing Memory Access Splitter

This block sits between a load/store pipeline stage and a data cache port. It accepts one memory request at a time, made up of a start address, an access size, a read/write flag and store data. It then decides whether the bytes touched stay inside one cache line. A request that fits in one line goes to the cache as a single access of the full size. A request that runs past the end of a line is sent as two sub-accesses in order. The first starts at the original address and stops at the line end. The second starts at the base of the next line and carries the remaining bytes.

The block counts the responses that come back. When the last one needed has arrived, it presents a single completion to the pipeline that carries the original address and size. For a load, the completion carries the bytes of both parts joined in little-endian order. For a store, it carries the original store data. An error reported on any sub-access marks the whole request as faulted. Only one request is in flight at a time, so the pipeline waits until the completion has been taken.

Top module: `line_split_unit`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_valid`, `rsp_ready` and `cpl_valid` are 0.
- R2: The size code maps 0, 1, 2, 3 to 1, 2, 4, 8 bytes. A request whose last byte lies in the same line as its first byte produces exactly one cache access, at the original address, with `mem_nbytes` equal to the full size.
- R3: A request is split when the line base of its last byte (start + bytes − 1, rounded down to `LINE_BYTES`) is strictly greater than the start address. An access that ends on the last byte of a line is not split.
- R4: The first sub-access of a split uses the original address and a byte count of (second line base − start address).
- R5: The second sub-access targets the second line base with a byte count of (start + total bytes − second line base). It is issued only after the response to the first has been accepted.
- R6: Write data on `mem_wdata` is packed from byte lane 0. For the second sub-access of a store, it equals the original store data shifted down by the first part's byte count. Lanes at or above `mem_nbytes` are zero.
- R7: Exactly one completion is raised per request, after the last needed response has been accepted. It carries the original address and size code, and it holds its contents while `cpl_ready` is low.
- R8: A load completion carries, in byte lane k, the k-th byte of the request. The first part's bytes fill the low lanes, the second part's bytes follow directly above, and lanes at or above the total size are zero. Response lanes at or above the sub-access byte count are ignored.
- R9: A store completion returns the original 64-bit store data unchanged on `cpl_data`.
- R10: `cpl_fault` is 1 when any sub-access of the request returned `rsp_err`, and 0 otherwise.
- R11: `req_ready` is 0 from the acceptance of a request until its completion has been taken.
- R12: `mem_be` has bit i set exactly when i < `mem_nbytes`, so it marks the packed lanes that are valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Pipeline request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte start address |
| req_size | input | 2 | Size code (1, 2, 4, 8 bytes) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 64 | Store data, byte 0 in lane 0 |
| mem_valid | output | 1 | Cache access valid |
| mem_ready | input | 1 | Cache accepts access |
| mem_addr | output | ADDR_W | Sub-access start address |
| mem_nbytes | output | 4 | Sub-access byte count |
| mem_be | output | 8 | Valid byte lanes of packed data |
| mem_write | output | 1 | Access is a store |
| mem_wdata | output | 64 | Packed store data for this access |
| rsp_valid | input | 1 | Cache response valid |
| rsp_ready | output | 1 | Block accepts response |
| rsp_rdata | input | 64 | Packed read data |
| rsp_err | input | 1 | Access error |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Pipeline takes completion |
| cpl_addr | output | ADDR_W | Original start address |
| cpl_size | output | 2 | Original size code |
| cpl_data | output | 64 | Merged load data or original store data |
| cpl_fault | output | 1 | Any sub-access failed |

## Verification
The hardest case to reach from the ports is the order and content of the second sub-access. It only exists when the first response has come back. Its data depends on how many bytes the first part took, and an error on it must still reach the single completion. The stimulus places requests one to seven bytes short of a line end, using every size code, for both loads and stores. A memory model answers each access with bytes derived from their addresses, fills unused lanes with junk, and can be told to fail one chosen address. The bench then compares each logged sub-access and the completion against values worked out from the request alone.

// File: rtl/lsu_split_pkg.sv
package lsu_split_pkg;
    localparam int unsigned MAX_BYTES = 8;
    localparam int unsigned DATA_W    = 8 * MAX_BYTES;
    localparam int unsigned CNT_W     = $clog2(MAX_BYTES) + 1;
    localparam int unsigned SIZE_W    = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } split_st_e;

    function automatic logic [CNT_W-1:0] size_to_bytes(input logic [SIZE_W-1:0] sz);
        return CNT_W'(1) << sz;
    endfunction
endpackage

// File: rtl/split_calc.sv
module split_calc
    import lsu_split_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic              crosses,
    output logic [ADDR_W-1:0] base2,
    output logic [CNT_W-1:0]  n1,
    output logic [CNT_W-1:0]  n2
);
    logic [CNT_W-1:0]  total;
    logic [ADDR_W-1:0] last_byte;
    logic [ADDR_W-1:0] last_base;
    logic [ADDR_W-1:0] head_len;

    always_comb begin
        total     = size_to_bytes(size);
        last_byte = addr + ADDR_W'(total) - ADDR_W'(1);
        last_base = last_byte & ~ADDR_W'(LINE_BYTES - 1);
        crosses   = last_base > addr;
        head_len  = last_base - addr;
        base2     = last_base;
        n1        = crosses ? CNT_W'(head_len) : total;
        n2        = crosses ? (total - CNT_W'(head_len)) : '0;
    end
endmodule

// File: rtl/lane_mask.sv
module lane_mask
    import lsu_split_pkg::*;
(
    input  logic [CNT_W-1:0]     nbytes,
    output logic [MAX_BYTES-1:0] be,
    output logic [DATA_W-1:0]    dmask
);
    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
        assign be[i]          = CNT_W'(i) < nbytes;
        assign dmask[8*i +: 8] = {8{be[i]}};
    end
endmodule

// File: rtl/load_merge.sv
module load_merge
    import lsu_split_pkg::*;
(
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [DATA_W-1:0] dmask,
    input  logic              second,
    input  logic [CNT_W-1:0]  head_bytes,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] slice;

    always_comb begin
        slice  = rsp_data & dmask;
        merged = second ? (acc | (slice << {head_bytes, 3'b000})) : slice;
    end
endmodule

// File: rtl/line_split_unit.sv
module line_split_unit
    import lsu_split_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic                 req_write,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [CNT_W-1:0]     mem_nbytes,
    output logic [MAX_BYTES-1:0] mem_be,
    output logic                 mem_write,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 rsp_valid,
    output logic                 rsp_ready,
    input  logic [DATA_W-1:0]    rsp_rdata,
    input  logic                 rsp_err,
    output logic                 cpl_valid,
    input  logic                 cpl_ready,
    output logic [ADDR_W-1:0]    cpl_addr,
    output logic [SIZE_W-1:0]    cpl_size,
    output logic [DATA_W-1:0]    cpl_data,
    output logic                 cpl_fault
);
    typedef struct packed {
        split_st_e         st;
        logic              part;
        logic [1:0]        done_cnt;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              crosses;
        logic [ADDR_W-1:0] base2;
        logic [CNT_W-1:0]  n1;
        logic [CNT_W-1:0]  n2;
        logic [DATA_W-1:0] acc;
        logic              fault;
    } split_state_t;

    split_state_t q, d;

    logic              calc_cross;
    logic [ADDR_W-1:0] calc_base2;
    logic [CNT_W-1:0]  calc_n1, calc_n2;
    logic [CNT_W-1:0]  cur_n;
    logic [DATA_W-1:0] cur_dmask;
    logic [DATA_W-1:0] merged;
    logic [1:0]        need_cnt;

    split_calc #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) calc_i (
        .addr    (req_addr),
        .size    (req_size),
        .crosses (calc_cross),
        .base2   (calc_base2),
        .n1      (calc_n1),
        .n2      (calc_n2)
    );

    assign cur_n = q.part ? q.n2 : q.n1;

    lane_mask mask_i (
        .nbytes (cur_n),
        .be     (mem_be),
        .dmask  (cur_dmask)
    );

    load_merge merge_i (
        .acc        (q.acc),
        .rsp_data   (rsp_rdata),
        .dmask      (cur_dmask),
        .second     (q.part),
        .head_bytes (q.n1),
        .merged     (merged)
    );

    assign need_cnt = q.crosses ? 2'd2 : 2'd1;

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st       = ST_ISSUE;
                    d.part     = 1'b0;
                    d.done_cnt = '0;
                    d.addr     = req_addr;
                    d.size     = req_size;
                    d.wr       = req_write;
                    d.wdata    = req_wdata;
                    d.crosses  = calc_cross;
                    d.base2    = calc_base2;
                    d.n1       = calc_n1;
                    d.n2       = calc_n2;
                    d.acc      = '0;
                    d.fault    = 1'b0;
                end
            end
            ST_ISSUE: begin
                if (mem_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    d.done_cnt = q.done_cnt + 2'd1;
                    d.fault    = q.fault | rsp_err;
                    if (!q.wr) d.acc = merged;
                    if (d.done_cnt == need_cnt) begin
                        d.st = ST_DONE;
                    end else begin
                        d.part = 1'b1;
                        d.st   = ST_ISSUE;
                    end
                end
            end
            ST_DONE: begin
                if (cpl_ready) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign mem_valid  = (q.st == ST_ISSUE);
    assign mem_addr   = q.part ? q.base2 : q.addr;
    assign mem_nbytes = cur_n;
    assign mem_write  = q.wr;
    assign mem_wdata  = (q.part ? (q.wdata >> {q.n1, 3'b000}) : q.wdata) & cur_dmask;
    assign rsp_ready  = (q.st == ST_WAIT);
    assign cpl_valid  = (q.st == ST_DONE);
    assign cpl_addr   = q.addr;
    assign cpl_size   = q.size;
    assign cpl_data   = q.wr ? q.wdata : q.acc;
    assign cpl_fault  = q.fault;
endmodule

// File: rtl/line_split_chk.sv
module line_split_chk
    import lsu_split_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_ready,
    input logic                 mem_valid,
    input logic                 mem_ready,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic [CNT_W-1:0]     mem_nbytes,
    input logic [MAX_BYTES-1:0] mem_be,
    input logic                 rsp_ready,
    input logic                 cpl_valid,
    input logic                 cpl_ready,
    input logic [ADDR_W-1:0]    cpl_addr,
    input logic [DATA_W-1:0]    cpl_data,
    input logic                 cpl_fault
);
    localparam int unsigned OFS_W = $clog2(LINE_BYTES);

    // R11: the block never takes a request while an access or completion is pending
    a_r11_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, mem_valid, rsp_ready, cpl_valid}));

    // R12: lane enables count equals the byte count
    a_r12_be_count: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ($countones(mem_be) == int'(mem_nbytes)));

    // R3: no issued access runs past the end of its line
    a_r3_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (int'(mem_addr[OFS_W-1:0]) + int'(mem_nbytes) <= int'(LINE_BYTES)));

    // R2: an access waiting for the cache keeps its address and size
    a_r2_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_nbytes)));

    // R7: a stalled completion keeps its contents
    a_r7_cpl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_addr) && $stable(cpl_data)
                                       && $stable(cpl_fault)));
endmodule

bind line_split_unit line_split_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_nbytes (mem_nbytes),
    .mem_be     (mem_be),
    .rsp_ready  (rsp_ready),
    .cpl_valid  (cpl_valid),
    .cpl_ready  (cpl_ready),
    .cpl_addr   (cpl_addr),
    .cpl_data   (cpl_data),
    .cpl_fault  (cpl_fault)
);

// File: tb/line_split_unit_tb_top.sv
module line_split_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr;
    logic [3:0]  mem_nbytes;
    logic [7:0]  mem_be;
    logic        mem_write;
    logic [63:0] mem_wdata;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [63:0] rsp_rdata = '0;
    logic        rsp_err = 1'b0;
    logic        cpl_valid;
    logic        cpl_ready = 1'b0;
    logic [31:0] cpl_addr;
    logic [1:0]  cpl_size;
    logic [63:0] cpl_data;
    logic        cpl_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] log_addr [4];
    logic [3:0]  log_n    [4];
    logic [7:0]  log_be   [4];
    logic        log_wr   [4];
    logic [63:0] log_wd   [4];
    int          log_cnt  = 0;
    int          rsp_done = 0;
    int          overlap  = 0;
    int          lat      = 1;
    logic [31:0] err_addr = 32'hFFFF_FFFF;

    always #10 clk = ~clk;

    line_split_unit #(.ADDR_W(32), .LINE_BYTES(64)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_nbytes(mem_nbytes), .mem_be(mem_be), .mem_write(mem_write),
        .mem_wdata(mem_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_addr(cpl_addr),
        .cpl_size(cpl_size), .cpl_data(cpl_data), .cpl_fault(cpl_fault)
    );

    // {addr, size code, write, store data}
    localparam int NVEC = 8;
    localparam logic [98:0] VEC [NVEC] = '{
        {32'h0000_0100, 2'd3, 1'b0, 64'h0},
        {32'h0000_013C, 2'd2, 1'b0, 64'h0},
        {32'h0000_013D, 2'd2, 1'b0, 64'h0},
        {32'h0000_017F, 2'd1, 1'b1, 64'h0000_0000_0000_A55A},
        {32'h0000_01F9, 2'd3, 1'b1, 64'h1122_3344_5566_7788},
        {32'h0000_0203, 2'd0, 1'b0, 64'h0},
        {32'h0000_023A, 2'd3, 1'b0, 64'h0},
        {32'h0000_027E, 2'd2, 1'b1, 64'h0000_0000_CAFE_F00D}
    };

    function automatic logic [7:0] fb(input logic [31:0] a);
        return 8'(a[7:0] * 8'd7 + 8'd3);
    endfunction

    function automatic logic [63:0] dm(input int n);
        logic [63:0] m = '0;
        for (int i = 0; i < 8; i++) if (i < n) m[8*i +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // memory model: one access at a time, junk in unused lanes
    initial begin
        forever begin
            @(negedge clk);
            if (mem_valid && rst_n) begin
                if (log_cnt < 4) begin
                    log_addr[log_cnt] = mem_addr;
                    log_n[log_cnt]    = mem_nbytes;
                    log_be[log_cnt]   = mem_be;
                    log_wr[log_cnt]   = mem_write;
                    log_wd[log_cnt]   = mem_wdata;
                end
                log_cnt++;
                mem_ready = 1'b1;
                rsp_rdata = {8{8'hEE}};
                for (int i = 0; i < 8; i++)
                    if (i < int'(mem_nbytes)) rsp_rdata[8*i +: 8] = fb(mem_addr + 32'(i));
                rsp_err = (mem_addr == err_addr);
                @(negedge clk);
                mem_ready = 1'b0;
                for (int k = 0; k < lat; k++) begin
                    if (mem_valid) overlap++;
                    @(negedge clk);
                end
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
                rsp_err   = 1'b0;
                rsp_done++;
            end
        end
    end

    task automatic run(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                       input logic [63:0] wd, input int hold, input logic exp_fault);
        int nb, n1, n2;
        logic [31:0] lb;
        bit split;
        logic [63:0] exp_ld;
        int seen_rsp;
        nb    = 1 << sz;
        lb    = (a + 32'(nb) - 32'd1) & ~32'd63;
        split = lb > a;
        n1    = split ? int'(lb - a) : nb;
        n2    = split ? nb - n1 : 0;
        exp_ld = '0;
        for (int k = 0; k < 8; k++) if (k < nb) exp_ld[8*k +: 8] = fb(a + 32'(k));
        log_cnt = 0; rsp_done = 0; overlap = 0;

        @(negedge clk);
        req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 req_ready low while busy", 64'(req_ready), 64'd0);
        while (!cpl_valid) @(negedge clk);
        seen_rsp = rsp_done;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R11 req_ready low during completion stall", 64'(req_ready), 64'd0);
            chk("R7 completion held", 64'(cpl_valid), 64'd1);
        end
        chk("R7 address", 64'(cpl_addr), 64'(a));
        chk("R7 size code", 64'(cpl_size), 64'(sz));
        chk("R7 all responses before completion", 64'(seen_rsp), 64'(split ? 2 : 1));
        chk("R2/R3 access count", 64'(log_cnt), 64'(split ? 2 : 1));
        chk("R4 first address", 64'(log_addr[0]), 64'(a));
        chk("R4 first byte count", 64'(log_n[0]), 64'(n1));
        chk("R12 first lane enables", 64'(log_be[0]), 64'((9'd1 << n1) - 9'd1));
        chk("R2 write flag", 64'(log_wr[0]), 64'(wr));
        if (wr) chk("R6 first store data", log_wd[0], wd & dm(n1));
        if (split) begin
            chk("R5 second address", 64'(log_addr[1]), 64'(lb));
            chk("R5 second byte count", 64'(log_n[1]), 64'(n2));
            chk("R5 no overlap with first", 64'(overlap), 64'd0);
            chk("R12 second lane enables", 64'(log_be[1]), 64'((9'd1 << n2) - 9'd1));
            if (wr) chk("R6 second store data", log_wd[1], (wd >> (8 * n1)) & dm(n2));
        end
        if (wr) chk("R9 store completion data", cpl_data, wd);
        else    chk("R8 merged load data", cpl_data, exp_ld);
        chk("R10 fault flag", 64'(cpl_fault), 64'(exp_fault));
        cpl_ready = 1'b1;
        @(negedge clk);
        cpl_ready = 1'b0;
        chk("R11 ready again after completion", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 req_ready in reset", 64'(req_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 mem_valid", 64'(mem_valid), 64'd0);
        chk("R1 rsp_ready", 64'(rsp_ready), 64'd0);
        chk("R1 cpl_valid", 64'(cpl_valid), 64'd0);

        for (int v = 0; v < NVEC; v++) begin
            lat = 1 + (v % 3);
            run(VEC[v][98:67], VEC[v][66:65], VEC[v][64], VEC[v][63:0], 0, 1'b0);
        end

        // R10: error on the second part of a split load
        err_addr = 32'h0000_0300;
        run(32'h0000_02FD, 2'd3, 1'b0, 64'h0, 0, 1'b1);
        // R10: error on the first part of a split store
        err_addr = 32'h0000_033E;
        run(32'h0000_033E, 2'd2, 1'b1, 64'h0102_0304_0506_0708, 0, 1'b1);
        // R10: error on an unsplit access
        err_addr = 32'h0000_0400;
        run(32'h0000_0400, 2'd2, 1'b0, 64'h0, 0, 1'b1);
        err_addr = 32'hFFFF_FFFF;
        // R7 R11: completion stall on a split store, then a clean request afterwards
        lat = 4;
        run(32'h0000_047B, 2'd3, 1'b1, 64'hDEAD_BEEF_0BAD_F00D, 3, 1'b0);
        run(32'h0000_04BF, 2'd0, 1'b0, 64'h0, 2, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule